// File: doc/BRIEF.md
# Two-Step Combination Lock Controller

This block is the control logic for a door lock that opens on a two-number code. The user sets a small switch value and pulses an enter input, then sets a second value and pulses enter again. Each entered value is compared with a fixed pair of code values chosen by parameter. After a correct pair the block asserts the open output. After any wrong entry it asserts the error output. Both outputs stay set until a reset.

A wrong first entry is recorded in the state, but the error output is held back until the second enter. Someone trying values at the door therefore cannot tell which of the two numbers was wrong. A parameter selects whether the state register uses a compact 3-bit binary code or a 5-bit one-hot code. Both choices produce the same output sequence for the same input stream.

Top module: `seq_lock_ctrl`

## Requirements
- R1: `rst_i` is sampled on the rising clock edge and returns the machine to its rest state. While `rst_i` is high, `open_o` and `error_o` are both low in that same cycle, whatever the current state.
- R2: In the rest state with `enter_i` low, the state holds and both outputs stay low for any `code_i` value.
- R3: A pulse on `enter_i` in the rest state with `code_i` equal to `FIRST_CODE` (default 2'b01) leads to a waiting state in which both outputs remain low.
- R4: A pulse on `enter_i` in the waiting state with `code_i` equal to `SECOND_CODE` (default 2'b11) raises `open_o` in the cycle after the clock edge that samples the pulse. `open_o` then stays high until reset.
- R5: A pulse on `enter_i` in the waiting state with any other code raises `error_o` in the cycle after the sampling edge. `error_o` then stays high until reset.
- R6: After a wrong first entry, both outputs stay low. The next `enter_i` pulse raises `error_o` whatever `code_i` holds at that time, including `SECOND_CODE`.
- R7: Once `open_o` or `error_o` is high, further `enter_i` pulses and `code_i` changes leave both outputs unchanged.
- R8: `open_o` and `error_o` are never high in the same cycle.
- R9: Only an exact match counts as correct. Entering `SECOND_CODE` first, or entering `FIRST_CODE` twice, ends in `error_o`.
- R10: With `ONE_HOT` = 1 the block produces, cycle for cycle, the same `open_o` and `error_o` as with `ONE_HOT` = 0. `FIRST_CODE` and `SECOND_CODE` must be set to different values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; everything is sampled on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high; highest priority |
| enter_i | input | 1 | Enter pulse, high for one clock per press |
| code_i | input | CODE_W (2) | Switch value offered for comparison |
| open_o | output | 1 | Door release; high after a correct pair |
| error_o | output | 1 | Error lamp; high after a wrong pair |

## Verification
Each enter pulse is sampled by one rising edge and updates the single state register. The outputs follow that register through decode logic only, so a result is due in the cycle right after the sampling edge. The reset gating of the outputs acts in the same cycle that `rst_i` rises. The bench changes inputs on falling edges and reads outputs one time step after the falling edge that follows the sampling edge. A reset check is read just after `rst_i` is raised, before any rising edge. A binary instance and a one-hot instance run side by side on the same stimulus, and every check also compares their outputs.

// File: rtl/seq_lock_pkg.sv
package seq_lock_pkg;

  // Logical states. The binary encoding uses these values directly.
  typedef enum logic [2:0] {
    LK_REST  = 3'b000,
    LK_ARMED = 3'b001,
    LK_OPEN  = 3'b010,
    LK_MISS  = 3'b101,
    LK_FAULT = 3'b110
  } lk_state_e;

  localparam int unsigned LK_NUM_STATES = 5;

  // Position of each state in the one-hot vector
  function automatic int unsigned lk_hot_index(lk_state_e s);
    case (s)
      LK_REST:  return 0;
      LK_ARMED: return 1;
      LK_OPEN:  return 2;
      LK_MISS:  return 3;
      default:  return 4;
    endcase
  endfunction

  // Next logical state; reset wins over every other input
  function automatic lk_state_e lk_step(lk_state_e s, logic rst, logic enter,
                                        logic hit_first, logic hit_second);
    lk_state_e n;
    n = s;
    if (rst) begin
      n = LK_REST;
    end else begin
      case (s)
        LK_REST:  if (enter) n = hit_first  ? LK_ARMED : LK_MISS;
        LK_ARMED: if (enter) n = hit_second ? LK_OPEN  : LK_FAULT;
        LK_MISS:  if (enter) n = LK_FAULT;
        LK_OPEN:  n = LK_OPEN;
        LK_FAULT: n = LK_FAULT;
        default:  n = LK_REST;
      endcase
    end
    return n;
  endfunction

endpackage

// File: rtl/lock_code_match.sv
module lock_code_match #(
  parameter int unsigned CODE_W = 2,
  parameter logic [CODE_W-1:0] FIRST_CODE  = 2'b01,
  parameter logic [CODE_W-1:0] SECOND_CODE = 2'b11
) (
  input  logic [CODE_W-1:0] code_i,
  output logic              hit_first_o,
  output logic              hit_second_o
);

  assign hit_first_o  = (code_i == FIRST_CODE);
  assign hit_second_o = (code_i == SECOND_CODE);

endmodule

// File: rtl/lock_state_codec.sv
module lock_state_codec
  import seq_lock_pkg::*;
#(
  parameter bit          ONE_HOT = 1'b0,
  parameter int unsigned ST_W    = 3
) (
  input  logic [ST_W-1:0] raw_i,
  input  lk_state_e       next_i,
  output lk_state_e       cur_o,
  output logic            illegal_o,
  output logic [ST_W-1:0] raw_next_o
);

  generate
    if (ONE_HOT) begin : g_hot
      always_comb begin
        raw_next_o = '0;
        raw_next_o[lk_hot_index(next_i)] = 1'b1;
      end

      always_comb begin
        cur_o     = LK_REST;
        illegal_o = ($countones(raw_i) != 1);
        if (!illegal_o) begin
          if (raw_i[lk_hot_index(LK_ARMED)]) cur_o = LK_ARMED;
          if (raw_i[lk_hot_index(LK_OPEN)])  cur_o = LK_OPEN;
          if (raw_i[lk_hot_index(LK_MISS)])  cur_o = LK_MISS;
          if (raw_i[lk_hot_index(LK_FAULT)]) cur_o = LK_FAULT;
        end
      end
    end else begin : g_bin
      assign raw_next_o = ST_W'(next_i);

      always_comb begin
        illegal_o = 1'b0;
        case (raw_i[2:0])
          3'b000:  cur_o = LK_REST;
          3'b001:  cur_o = LK_ARMED;
          3'b010:  cur_o = LK_OPEN;
          3'b101:  cur_o = LK_MISS;
          3'b110:  cur_o = LK_FAULT;
          default: begin
            cur_o     = LK_REST;
            illegal_o = 1'b1;
          end
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/lock_state_reg.sv
module lock_state_reg #(
  parameter int unsigned ST_W = 3
) (
  input  logic            clk_i,
  input  logic [ST_W-1:0] d_i,
  output logic [ST_W-1:0] q_o
);

  // The reset value is already folded into d_i by the next-state logic
  always_ff @(posedge clk_i) begin
    q_o <= d_i;
  end

endmodule

// File: rtl/seq_lock_ctrl.sv
module seq_lock_ctrl
  import seq_lock_pkg::*;
#(
  parameter int unsigned       CODE_W      = 2,
  parameter logic [CODE_W-1:0] FIRST_CODE  = 2'b01,
  parameter logic [CODE_W-1:0] SECOND_CODE = 2'b11,
  parameter bit                ONE_HOT     = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              enter_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              open_o,
  output logic              error_o
);

  localparam int unsigned ST_W = ONE_HOT ? LK_NUM_STATES : 3;

  // Named internal events, also observed by the bound checker
  logic            first_hit;
  logic            second_hit;
  logic            illegal_st;
  logic            in_rest;
  lk_state_e       cur_st;
  lk_state_e       nxt_st;
  logic [ST_W-1:0] st_q;
  logic [ST_W-1:0] st_d;

  lock_code_match #(
    .CODE_W      (CODE_W),
    .FIRST_CODE  (FIRST_CODE),
    .SECOND_CODE (SECOND_CODE)
  ) u_match (
    .code_i       (code_i),
    .hit_first_o  (first_hit),
    .hit_second_o (second_hit)
  );

  lock_state_codec #(
    .ONE_HOT (ONE_HOT),
    .ST_W    (ST_W)
  ) u_codec (
    .raw_i      (st_q),
    .next_i     (nxt_st),
    .cur_o      (cur_st),
    .illegal_o  (illegal_st),
    .raw_next_o (st_d)
  );

  lock_state_reg #(
    .ST_W (ST_W)
  ) u_reg (
    .clk_i (clk_i),
    .d_i   (st_d),
    .q_o   (st_q)
  );

  // An unused encoding goes back to rest regardless of the inputs
  assign nxt_st  = illegal_st ? LK_REST
                              : lk_step(cur_st, rst_i, enter_i, first_hit, second_hit);
  assign in_rest = (cur_st == LK_REST);

  assign open_o  = (cur_st == LK_OPEN)  && !rst_i;
  assign error_o = (cur_st == LK_FAULT) && !rst_i;

endmodule

// File: rtl/seq_lock_chk.sv
module seq_lock_chk (
  input logic clk_i,
  input logic rst_i,
  input logic enter_i,
  input logic open_o,
  input logic error_o,
  input logic in_rest,
  input logic first_hit,
  input logic second_hit
);

  // R1: reset leads to rest on the following cycle
  a_r1_reset_rest: assert property (@(posedge clk_i) rst_i |=> in_rest);

  // R1: outputs are low during reset
  a_r1_reset_quiet: assert property (@(posedge clk_i) rst_i |-> (!open_o && !error_o));

  // R2: idle rest holds
  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    (in_rest && !enter_i) |=> in_rest);

  // R4: open appears only after an enter with the second value
  a_r4_open_cause: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(open_o) |-> $past(enter_i && second_hit));

  // R4 / R7: open stays high until reset
  a_r4_open_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    open_o |=> open_o);

  // R5 / R7: error stays high until reset
  a_r5_error_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    error_o |=> error_o);

  // R6: the first entry never raises error at once
  a_r6_no_early_error: assert property (@(posedge clk_i) disable iff (rst_i)
    (in_rest && enter_i) |=> !error_o);

  // R3: a matching first entry raises neither output
  a_r3_first_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
    (in_rest && enter_i && first_hit) |=> (!open_o && !error_o));

  // R8: the two outputs are exclusive
  a_r8_exclusive: assert property (@(posedge clk_i) !(open_o && error_o));

endmodule

bind seq_lock_ctrl seq_lock_chk u_chk (.*);

// File: tb/tb_seq_lock_ctrl.sv
module tb_seq_lock_ctrl;

  localparam logic [1:0] C_FIRST  = 2'b01;
  localparam logic [1:0] C_SECOND = 2'b11;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enter = 1'b0;
  logic [1:0] code = 2'b00;
  logic       open_b, err_b, open_h, err_h;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  seq_lock_ctrl #(.FIRST_CODE(C_FIRST), .SECOND_CODE(C_SECOND), .ONE_HOT(1'b0)) dut (
    .clk_i(clk), .rst_i(rst), .enter_i(enter), .code_i(code),
    .open_o(open_b), .error_o(err_b));

  seq_lock_ctrl #(.FIRST_CODE(C_FIRST), .SECOND_CODE(C_SECOND), .ONE_HOT(1'b1)) dut_oh (
    .clk_i(clk), .rst_i(rst), .enter_i(enter), .code_i(code),
    .open_o(open_h), .error_o(err_h));

  task automatic check(input string req, input logic exp_open, input logic exp_err);
    total++;
    if (open_b !== exp_open || err_b !== exp_err) begin
      bad++;
      $display("FAIL %s: open=%b error=%b expected open=%b error=%b",
               req, open_b, err_b, exp_open, exp_err);
    end
    total++;
    if (open_h !== open_b || err_h !== err_b) begin
      bad++;
      $display("FAIL R10: one-hot open=%b error=%b expected open=%b error=%b",
               open_h, err_h, open_b, err_b);
    end
    total++;
    if (open_b && err_b) begin
      bad++;
      $display("FAIL R8: open=%b error=%b expected not both high", open_b, err_b);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    enter = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 rest after reset", 1'b0, 1'b0);
  endtask

  task automatic press(input logic [1:0] c);
    @(negedge clk);
    code = c;
    enter = 1'b1;
    @(negedge clk);
    enter = 1'b0;
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      code = code + 2'd1;
    end
    #1;
  endtask

  task automatic t_idle_rest();
    do_reset();
    idle(7);
    check("R2 idle in rest", 1'b0, 1'b0);
  endtask

  task automatic t_good_pair();
    do_reset();
    press(C_FIRST);
    check("R3 after correct first", 1'b0, 1'b0);
    press(C_SECOND);
    check("R4 open after correct pair", 1'b1, 1'b0);
    idle(5);
    check("R4 open held", 1'b1, 1'b0);
    press(2'b00);
    check("R7 enter ignored when open", 1'b1, 1'b0);
    press(C_FIRST);
    check("R7 enter ignored when open", 1'b1, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    #1;
    check("R1 outputs low during reset", 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 rest after reset from open", 1'b0, 1'b0);
  endtask

  task automatic t_bad_second();
    do_reset();
    press(C_FIRST);
    press(2'b00);
    check("R5 error after wrong second", 1'b0, 1'b1);
    idle(4);
    check("R5 error held", 1'b0, 1'b1);
    press(C_SECOND);
    check("R7 enter ignored when error", 1'b0, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    #1;
    check("R1 outputs low during reset", 1'b0, 1'b0);
  endtask

  task automatic t_bad_first();
    do_reset();
    press(2'b10);
    check("R6 no error after wrong first", 1'b0, 1'b0);
    idle(3);
    check("R6 still quiet", 1'b0, 1'b0);
    press(C_SECOND);
    check("R6 error on second enter", 1'b0, 1'b1);
  endtask

  task automatic t_exact_match();
    do_reset();
    press(C_SECOND);
    check("R9 second value first is quiet", 1'b0, 1'b0);
    press(C_SECOND);
    check("R9 second value first ends in error", 1'b0, 1'b1);
    do_reset();
    press(C_FIRST);
    press(C_FIRST);
    check("R9 first value twice ends in error", 1'b0, 1'b1);
  endtask

  initial begin
    #1;
    check("R1 outputs low in reset", 1'b0, 1'b0);
    t_idle_rest();
    t_good_pair();
    t_bad_second();
    t_bad_first();
    t_exact_match();
    t_good_pair();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule